// File: doc/BRIEF.md
# Filtered Input Capture Channel

This block is a single capture/compare channel that sits beside a free-running 16-bit count supplied from outside. In capture mode an asynchronous input pin is brought into the clock domain by a two-stage synchronizer. It then passes a sample-count glitch filter, so that only level changes held for 1, 2, 4 or 8 clock samples are accepted. The accepted rising, falling or both edges are thinned by an event prescaler, and every resulting capture event latches the count into the channel value register.

Each capture raises a capture flag. If a new capture arrives while that flag is still set, an over-capture flag is raised as well. In capture mode the value register cannot be written. In compare mode software writes the value, and the same flag instead rises whenever the count equals that value. Both flags are cleared by one-cycle clear strobes, and a set in the same cycle as a clear wins.

Top module: `cc_capture_channel`

## Requirements
- R1: With `mode_cap_i` = 0 (compare mode), a write strobe loads `wr_data_i` into `value_o` on the next clock. `cap_flag_o` becomes 1 on the clock edge at which `count_i` equals `value_o`.
- R2: The pin is synchronized by two flops and filtered. With `filt_sel_i` = 0, 1, 2 or 3, a new level must be seen on 1, 2, 4 or 8 consecutive clocks before it is accepted, and shorter pulses are dropped. A pin change first sampled at clock edge k yields a capture at edge k+N+2, where N is that sample count.
- R3: `edge_sel_i` = 0 selects rising edges, 1 selects falling edges, and 3 selects both. Encoding 2 also acts as both. Unselected edges cause no capture.
- R4: `psc_sel_i` = 0, 1, 2 or 3 captures on every 1st, 2nd, 4th or 8th selected edge. The edge counter is cleared while capture is disabled or while the channel is in compare mode.
- R5: No capture takes place while `cap_en_i` = 0.
- R6: A capture loads the `count_i` value present at the capture edge into `value_o`. Writes are ignored in capture mode.
- R7: Each capture sets `cap_flag_o`. `clr_cap_i` clears it, and a set wins over a clear in the same cycle.
- R8: `ovr_flag_o` is set when a capture occurs while `cap_flag_o` is already 1. `clr_ovr_i` clears it. It is never set in compare mode.
- R9: After reset, `value_o` is 0, both flags are 0, and the filtered level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also used as the filter sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| count_i | input | 16 | Free-running count to capture or compare |
| pin_i | input | 1 | Asynchronous capture input |
| mode_cap_i | input | 1 | 0 = output compare, 1 = input capture |
| cap_en_i | input | 1 | Capture enable |
| edge_sel_i | input | 2 | Edge select: 0 rising, 1 falling, 3 both |
| filt_sel_i | input | 2 | Filter length select (1/2/4/8 samples) |
| psc_sel_i | input | 2 | Event prescaler select (1/2/4/8) |
| wr_en_i | input | 1 | Software write strobe for the value register |
| wr_data_i | input | 16 | Software write data |
| clr_cap_i | input | 1 | Clear strobe for the capture/compare flag |
| clr_ovr_i | input | 1 | Clear strobe for the over-capture flag |
| value_o | output | 16 | Captured or programmed value |
| cap_flag_o | output | 1 | Capture/compare flag |
| ovr_flag_o | output | 1 | Over-capture flag |

## Verification
The assertions assume that the configuration inputs are changed only between bursts of pin activity. They also assume that clear strobes are single-cycle pulses, and that the count advances by the outside counter alone. The stimulus changes every control input on the falling clock edge and only while the pin is idle. It holds random pulse widths to at least ten clocks, so every pin change outlives the longest filter. Short glitches are applied only in directed cases that are meant to be dropped.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int CC_SEL_W = 2;
  localparam int CC_RUN_W = 4;

  typedef enum logic [CC_SEL_W-1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_ALT  = 2'd2,
    EDGE_BOTH = 2'd3
  } cc_edge_e;

  // Samples needed before a new level is accepted: 1, 2, 4, 8
  function automatic logic [CC_RUN_W-1:0] filt_need(input logic [CC_SEL_W-1:0] sel);
    return CC_RUN_W'(1) << sel;
  endfunction

  // Selected edges per capture event: 1, 2, 4, 8
  function automatic logic [CC_RUN_W-1:0] psc_ratio(input logic [CC_SEL_W-1:0] sel);
    return CC_RUN_W'(1) << sel;
  endfunction

  function automatic logic edge_hit(input logic [CC_SEL_W-1:0] sel,
                                    input logic rise, input logic fall);
    case (cc_edge_e'(sel))
      EDGE_RISE: return rise;
      EDGE_FALL: return fall;
      default:   return rise | fall;
    endcase
  endfunction
endpackage

// File: rtl/cc_in_filter.sv
module cc_in_filter
  import cc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pin_i,
  input  logic [CC_SEL_W-1:0] sel_i,
  output logic                rise_o,
  output logic                fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   samp;
  logic                   lvl_q;
  logic [CC_RUN_W-1:0]    run_q;
  logic [CC_RUN_W-1:0]    run_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
  end

  assign samp   = sync_q[SYNC_STAGES-1];
  assign run_nx = run_q + CC_RUN_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      run_q  <= '0;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      rise_o <= 1'b0;
      fall_o <= 1'b0;
      if (samp == lvl_q) begin
        run_q <= '0;
      end else if (run_nx >= filt_need(sel_i)) begin
        lvl_q  <= samp;
        run_q  <= '0;
        rise_o <= samp;
        fall_o <= ~samp;
      end else begin
        run_q <= run_nx;
      end
    end
  end
endmodule

// File: rtl/cc_evt_prescaler.sv
module cc_evt_prescaler
  import cc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                arm_i,
  input  logic [CC_SEL_W-1:0] edge_sel_i,
  input  logic [CC_SEL_W-1:0] psc_sel_i,
  input  logic                rise_i,
  input  logic                fall_i,
  output logic                evt_o
);
  logic                hit;
  logic                last;
  logic [CC_RUN_W-1:0] pcnt_q;

  assign hit   = edge_hit(edge_sel_i, rise_i, fall_i);
  assign last  = (pcnt_q == psc_ratio(psc_sel_i) - CC_RUN_W'(1));
  assign evt_o = arm_i & hit & last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pcnt_q <= '0;
    else if (!arm_i)     pcnt_q <= '0;
    else if (hit)        pcnt_q <= last ? '0 : pcnt_q + CC_RUN_W'(1);
  end
endmodule

// File: rtl/cc_value_latch.sv
module cc_value_latch #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_cap_i,
  input  logic             evt_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             clr_cap_i,
  input  logic             clr_ovr_i,
  output logic [CNT_W-1:0] value_o,
  output logic             flag_o,
  output logic             ovr_o
);
  logic match;
  logic flag_set;

  assign match    = ~mode_cap_i & (count_i == value_o);
  assign flag_set = evt_i | match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     value_o <= '0;
    else if (evt_i)                 value_o <= count_i;
    else if (!mode_cap_i && wr_en_i) value_o <= wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag_o <= 1'b0;
    else if (flag_set)  flag_o <= 1'b1;
    else if (clr_cap_i) flag_o <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ovr_o <= 1'b0;
    else if (evt_i && flag_o)   ovr_o <= 1'b1;
    else if (clr_ovr_i)         ovr_o <= 1'b0;
  end
endmodule

// File: rtl/cc_capture_channel.sv
module cc_capture_channel
  import cc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_i,
  input  logic             pin_i,
  input  logic             mode_cap_i,
  input  logic             cap_en_i,
  input  logic [1:0]       edge_sel_i,
  input  logic [1:0]       filt_sel_i,
  input  logic [1:0]       psc_sel_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             clr_cap_i,
  input  logic             clr_ovr_i,
  output logic [CNT_W-1:0] value_o,
  output logic             cap_flag_o,
  output logic             ovr_flag_o
);
  logic filt_rise;
  logic filt_fall;
  logic cap_arm;
  logic cap_evt;

  assign cap_arm = mode_cap_i & cap_en_i;

  cc_in_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filter (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (pin_i),
    .sel_i  (filt_sel_i),
    .rise_o (filt_rise),
    .fall_o (filt_fall)
  );

  cc_evt_prescaler u_psc (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_i      (cap_arm),
    .edge_sel_i (edge_sel_i),
    .psc_sel_i  (psc_sel_i),
    .rise_i     (filt_rise),
    .fall_i     (filt_fall),
    .evt_o      (cap_evt)
  );

  cc_value_latch #(.CNT_W(CNT_W)) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_cap_i (mode_cap_i),
    .evt_i      (cap_evt),
    .count_i    (count_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .clr_cap_i  (clr_cap_i),
    .clr_ovr_i  (clr_ovr_i),
    .value_o    (value_o),
    .flag_o     (cap_flag_o),
    .ovr_o      (ovr_flag_o)
  );
endmodule

// File: rtl/cc_capture_channel_chk.sv
module cc_capture_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_cap_i,
  input logic             cap_en_i,
  input logic [CNT_W-1:0] count_i,
  input logic [CNT_W-1:0] value_o,
  input logic             cap_flag_o,
  input logic             ovr_flag_o,
  input logic             cap_evt,
  input logic             filt_rise,
  input logic             filt_fall
);
  AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> value_o == $past(count_i)); // R6
  AST_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cap_i && !cap_evt) |=> $stable(value_o)); // R6
  AST_NO_CAPTURE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cap_i && !cap_en_i) |=> $stable(value_o)); // R5
  AST_FLAG_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> cap_flag_o); // R7
  AST_OVR_ONLY_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag_o) |-> $past(mode_cap_i)); // R8
  AST_OVR_NEEDS_PRIOR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag_o) |-> $past(cap_flag_o)); // R8
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({filt_rise, filt_fall})); // R2
  AST_EVT_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |-> (filt_rise || filt_fall)); // R3
endmodule

bind cc_capture_channel cc_capture_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_cap_i (mode_cap_i),
  .cap_en_i   (cap_en_i),
  .count_i    (count_i),
  .value_o    (value_o),
  .cap_flag_o (cap_flag_o),
  .ovr_flag_o (ovr_flag_o),
  .cap_evt    (cap_evt),
  .filt_rise  (filt_rise),
  .filt_fall  (filt_fall)
);

// File: tb/cc_capture_channel_bench.sv
`timescale 1ns/1ps
module cc_capture_channel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt = 16'd0;
  logic        pin = 1'b0;
  logic        mode_cap = 1'b1;
  logic        cap_en = 1'b1;
  logic [1:0]  edge_sel = 2'd0;
  logic [1:0]  filt_sel = 2'd0;
  logic [1:0]  psc_sel = 2'd0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = 16'd0;
  logic        clr_cap = 1'b0;
  logic        clr_ovr = 1'b0;
  logic [15:0] value;
  logic        cap_flag;
  logic        ovr_flag;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int unsigned seed = 32'd1234;

  always #10 clk = ~clk;
  always @(posedge clk) cnt <= cnt + 16'd1;

  cc_capture_channel u_cc_capture_channel (
    .clk(clk), .rst_n(rst_n), .count_i(cnt), .pin_i(pin),
    .mode_cap_i(mode_cap), .cap_en_i(cap_en), .edge_sel_i(edge_sel),
    .filt_sel_i(filt_sel), .psc_sel_i(psc_sel), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .clr_cap_i(clr_cap), .clr_ovr_i(clr_ovr),
    .value_o(value), .cap_flag_o(cap_flag), .ovr_flag_o(ovr_flag)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
      $finish;
    end
  end

  // Bench view of the requirements
  function automatic int need_of(input logic [1:0] f); return 1 << f; endfunction
  function automatic int ratio_of(input logic [1:0] p); return 1 << p; endfunction
  function automatic logic [15:0] exp_cap(input logic [15:0] c, input logic [1:0] f);
    return c + 16'(need_of(f)) + 16'd2;
  endfunction
  function automatic bit sel_hits(input logic [1:0] e, input logic lvl);
    if (e == 2'd0) return lvl;
    if (e == 2'd1) return !lvl;
    return 1'b1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_pin(input logic v, output logic [15:0] c);
    @(negedge clk);
    pin = v;
    c = cnt;
  endtask

  task automatic clear_all();
    @(negedge clk);
    clr_cap = 1'b1; clr_ovr = 1'b1;
    @(negedge clk);
    clr_cap = 1'b0; clr_ovr = 1'b0;
  endtask

  task automatic rearm();
    @(negedge clk); cap_en = 1'b0;
    @(negedge clk); cap_en = 1'b1;
  endtask

  initial begin
    logic [15:0] c, c2, keep, expv;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R9 reset state
    chk("R9 value", value, 0);
    chk("R9 flag", cap_flag, 0);
    chk("R9 ovr", ovr_flag, 0);
    cyc(10);
    chk("R9 filter level low, no spurious capture", cap_flag, 0);

    // R2 latency per filter length, rising edges
    for (int f = 0; f < 4; f++) begin
      filt_sel = 2'(f);
      clear_all();
      drive_pin(1'b1, c);
      cyc(14);
      chk("R2 capture latency", value, exp_cap(c, 2'(f)));
      chk("R7 flag on capture", cap_flag, 1);
      clear_all();
      keep = value;
      drive_pin(1'b0, c);
      cyc(14);
      chk("R3 falling ignored with rising select", value, keep);
      chk("R3 no flag on unselected edge", cap_flag, 0);
    end

    // R2 glitch shorter than the filter is dropped
    filt_sel = 2'd2;
    keep = value;
    drive_pin(1'b1, c);
    cyc(2);
    drive_pin(1'b0, c);
    cyc(14);
    chk("R2 glitch dropped flag", cap_flag, 0);
    chk("R2 glitch dropped value", value, keep);

    // R3 falling select
    filt_sel = 2'd1; edge_sel = 2'd1;
    drive_pin(1'b1, c);
    cyc(14);
    chk("R3 rise ignored with falling select", cap_flag, 0);
    drive_pin(1'b0, c);
    cyc(14);
    chk("R3 falling capture", value, exp_cap(c, 2'd1));

    // R3 both edges
    edge_sel = 2'd3; filt_sel = 2'd0;
    clear_all();
    drive_pin(1'b1, c);
    cyc(12);
    chk("R3 both: rise", value, exp_cap(c, 2'd0));
    drive_pin(1'b0, c);
    cyc(12);
    chk("R3 both: fall", value, exp_cap(c, 2'd0));

    // R4 prescaler ratio 4
    edge_sel = 2'd0; psc_sel = 2'd2;
    rearm();
    clear_all();
    for (int i = 0; i < 4; i++) begin
      drive_pin(1'b1, c);
      cyc(10);
      if (i == 2) chk("R4 no capture before 4th edge", cap_flag, 0);
      drive_pin(1'b0, c2);
      cyc(10);
      if (i == 3) chk("R4 capture on 4th edge", value, exp_cap(c, 2'd0));
    end

    // R4 prescaler counter cleared by disable
    psc_sel = 2'd1;
    rearm();
    clear_all();
    drive_pin(1'b1, c); cyc(10); drive_pin(1'b0, c); cyc(10);
    rearm();
    drive_pin(1'b1, c); cyc(10); drive_pin(1'b0, c2); cyc(10);
    chk("R4 counter cleared by disable", cap_flag, 0);
    drive_pin(1'b1, c); cyc(10); drive_pin(1'b0, c2); cyc(10);
    chk("R4 capture after rearm", value, exp_cap(c, 2'd0));
    psc_sel = 2'd0;

    // R5 capture disabled
    clear_all();
    cap_en = 1'b0;
    keep = value;
    drive_pin(1'b1, c); cyc(10); drive_pin(1'b0, c); cyc(10);
    chk("R5 disabled no flag", cap_flag, 0);
    chk("R5 disabled value kept", value, keep);
    cap_en = 1'b1;

    // R6 write ignored in capture mode
    @(negedge clk); wr_en = 1'b1; wr_data = ~keep;
    @(negedge clk); wr_en = 1'b0;
    cyc(1);
    chk("R6 write ignored in capture", value, keep);

    // R8 over-capture
    clear_all();
    drive_pin(1'b1, c); cyc(10); drive_pin(1'b0, c); cyc(10);
    chk("R8 single capture no ovr", ovr_flag, 0);
    drive_pin(1'b1, c); cyc(10); drive_pin(1'b0, c); cyc(10);
    chk("R8 second capture sets ovr", ovr_flag, 1);
    clear_all();
    chk("R8 ovr cleared", ovr_flag, 0);
    drive_pin(1'b1, c); cyc(10); drive_pin(1'b0, c); cyc(10);
    chk("R8 capture after clear no ovr", ovr_flag, 0);
    clear_all();

    // R1 compare mode
    @(negedge clk); mode_cap = 1'b0; wr_en = 1'b1; wr_data = cnt + 16'd40;
    expv = wr_data;
    @(negedge clk); wr_en = 1'b0; clr_cap = 1'b1;
    @(negedge clk); clr_cap = 1'b0;
    chk("R1 compare write", value, expv);
    cyc(10);
    chk("R1 no flag before match", cap_flag, 0);
    drive_pin(1'b1, c); cyc(6); drive_pin(1'b0, c); cyc(6);
    chk("R8 no ovr in compare mode", ovr_flag, 0);
    chk("R1 pin edges do not load in compare", value, expv);
    cyc(30);
    chk("R1 flag on match", cap_flag, 1);
    mode_cap = 1'b1;
    clear_all();

    // Random rounds
    for (int r = 0; r < 8; r++) begin
      int hits, caps, e;
      logic lvl;
      filt_sel = 2'($urandom(seed) % 4);
      e = $urandom % 3; edge_sel = (e == 2) ? 2'd3 : 2'(e);
      psc_sel = 2'($urandom % 4);
      rearm();
      clear_all();
      keep = value; expv = keep; hits = 0; caps = 0; lvl = pin;
      for (int p = 0; p < 24; p++) begin
        lvl = !lvl;
        drive_pin(lvl, c);
        if (sel_hits(edge_sel, lvl)) begin
          hits++;
          if (hits % ratio_of(psc_sel) == 0) begin
            caps++;
            expv = exp_cap(c, filt_sel);
          end
        end
        cyc(10 + ($urandom % 16));
      end
      cyc(14);
      chk("R6 random capture value", value, expv);
      chk("R4 random flag", cap_flag, (caps > 0));
      chk("R8 random ovr", ovr_flag, (caps > 1));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule